// File: doc/BRIEF.md
# Plug-and-Play Configuration Register Space with Shift-Chain Activation

This block holds the addressed configuration registers of a plug-and-play adapter once the card has been singled out by the enumeration controller. Host software reads a resource description one byte at a time. A status flag paces these reads: software polls the flag, reads the byte, and the flag clears until the block has fetched the next byte internally. Software then writes the assigned settings: a 16-bit I/O base, a 4-bit interrupt level and a 2-bit interrupt type.

Setting the activation bit starts a serial copy of those settings into the device's own configuration registers, one bit per clock. The device-active output is held low until the last bit has left the chain. All register access depends on the state reported by the enumeration controller. Outside the configuration state, reads return zero and writes are discarded.

Every byte of the resource description is produced by a fixed formula: byte n is the low 8 bits of 37·n + 90, with n wrapping after RES_LEN bytes. This stands in for the resource ROM, which lies outside this block.

Top module: `cfg_space_top`

## Requirements
- R1: After reset, `dev_active` and `chain_en` are 0, `rd_data` is 0x00, and the resource pointer is at byte 0.
- R2: Unless `ctl_state` is 3 (configuration; 0 = wait-for-key, 1 = sleep, 2 = isolation), every read returns 0x00 and every write is discarded. A read of index 0x04 in another state does not advance the resource pointer.
- R3: Unassigned indices read 0x00. Unused bits read 0: index 0x70 keeps only bits [3:0] and index 0x71 keeps only bits [1:0]. Indices 0x60 (I/O base high) and 0x61 (I/O base low) keep all 8 bits.
- R4: Bit 0 of index 0x05 (resource status) goes to 1 after exactly FETCH_LAT clock edges once reset is released. Bits [7:1] of index 0x05 read 0.
- R5: Reading index 0x04 while the status bit is 1 returns the current byte and clears the status bit. The status bit returns to 1 FETCH_LAT edges after that read.
- R6: Successive valid reads of index 0x04 return byte n = (37·n + 90) mod 256, for n = 0, 1, 2, … The index n wraps to 0 after RES_LEN bytes.
- R7: Reading index 0x04 while the status bit is 0 returns the previous byte and does not advance the pointer.
- R8: Writing index 0x30 with bit 0 set starts the transfer. `chain_en` is 1 for exactly 22 consecutive cycles, starting the cycle after the write edge. During those cycles `chain_sdata` carries {I/O base high, I/O base low, IRQ level[3:0], IRQ type[1:0]}, MSB first. Index 0x30 reads back the activation bit in bit 0.
- R9: `dev_active` is 0 while the chain is shifting. It becomes 1 in the cycle after the last bit, if the activation bit is set. Writing 0 to bit 0 of index 0x30 drops `dev_active` after the write edge.
- R10: Any write that arrives while the chain is shifting is discarded. This covers writes to the setting registers and to the activation bit.
- R11: `rd_data` is registered. It changes only on an edge where `rd_stb` is 1, and it holds its value otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_idx | input | 8 | Register index for the read or write |
| rd_stb | input | 1 | Read strobe, one cycle per read |
| wr_stb | input | 1 | Write strobe, one cycle per write |
| wr_data | input | 8 | Write data |
| ctl_state | input | 2 | Enumeration controller state (3 = configuration) |
| rd_data | output | 8 | Registered read data |
| chain_sdata | output | 1 | Serial settings bit for the device register chain |
| chain_en | output | 1 | Shift enable for the device register chain |
| dev_active | output | 1 | Releases the rest of the device |

## Verification
A resource pointer that slips or double-advances shows up on the next valid read of index 0x04: the returned byte does not fit the formula. A fetch counter with the wrong latency shows up within FETCH_LAT+1 edges, because the status bit at index 0x05 rises too early or too late. A bad shift register or bit counter is visible during the 22 transfer cycles: a bit comes out in the wrong place, or `chain_en` has the wrong length. A busy or done flag that is out of step drives `dev_active` high before the chain finishes, or leaves it low afterwards.

// File: rtl/cfg_space_pkg.sv
package cfg_space_pkg;

    typedef enum logic [1:0] {
        ST_WAIT_KEY = 2'd0,
        ST_SLEEP    = 2'd1,
        ST_ISOLATE  = 2'd2,
        ST_CONFIG   = 2'd3
    } ctl_state_e;

    localparam int IDX_W = 8;
    localparam int DAT_W = 8;

    localparam logic [IDX_W-1:0] IDX_RES_DATA = 8'h04;
    localparam logic [IDX_W-1:0] IDX_RES_STAT = 8'h05;
    localparam logic [IDX_W-1:0] IDX_ACTIVATE = 8'h30;
    localparam logic [IDX_W-1:0] IDX_IO_HI    = 8'h60;
    localparam logic [IDX_W-1:0] IDX_IO_LO    = 8'h61;
    localparam logic [IDX_W-1:0] IDX_IRQ_LVL  = 8'h70;
    localparam logic [IDX_W-1:0] IDX_IRQ_TYP  = 8'h71;

    localparam int IRQ_LVL_W = 4;
    localparam int IRQ_TYP_W = 2;

    // Field order equals shift order: first field leaves the chain first.
    typedef struct packed {
        logic [DAT_W-1:0]     io_hi;
        logic [DAT_W-1:0]     io_lo;
        logic [IRQ_LVL_W-1:0] irq_lvl;
        logic [IRQ_TYP_W-1:0] irq_typ;
    } settings_t;

    localparam int CHAIN_W = $bits(settings_t);

    // Stand-in for the resource ROM contents.
    function automatic logic [DAT_W-1:0] res_byte(input int unsigned n);
        return DAT_W'(n * 37 + 90);
    endfunction

endpackage

// File: rtl/cfg_res_port.sv
module cfg_res_port
    import cfg_space_pkg::*;
#(
    parameter int FETCH_LAT = 4,
    parameter int RES_LEN   = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             take,
    output logic [DAT_W-1:0] byte_q,
    output logic             valid_q
);
    localparam int PTR_W = (RES_LEN > 1) ? $clog2(RES_LEN) : 1;
    localparam int CNT_W = $clog2(FETCH_LAT + 1);
    localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(RES_LEN - 1);
    localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(FETCH_LAT);
    localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);

    logic [PTR_W-1:0] ptr_q;
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr_q   <= '0;
            cnt_q   <= CNT_LOAD;
            valid_q <= 1'b0;
            byte_q  <= '0;
        end else if (take && valid_q) begin
            valid_q <= 1'b0;
            cnt_q   <= CNT_LOAD;
            ptr_q   <= (ptr_q == PTR_LAST) ? '0 : ptr_q + PTR_W'(1);
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - CNT_ONE;
            if (cnt_q == CNT_ONE) begin
                valid_q <= 1'b1;
                byte_q  <= res_byte(32'(ptr_q));
            end
        end
    end

endmodule

// File: rtl/cfg_regs.sv
module cfg_regs
    import cfg_space_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] idx,
    input  logic [DAT_W-1:0] wdata,
    input  logic             busy,
    output settings_t        set_q,
    output logic             act_q,
    output logic             start
);
    logic wr_ok;

    assign wr_ok = wr_en && !busy;
    assign start = wr_ok && (idx == IDX_ACTIVATE) && wdata[0];

    always_ff @(posedge clk) begin
        if (rst) begin
            set_q <= '0;
            act_q <= 1'b0;
        end else if (wr_ok) begin
            case (idx)
                IDX_ACTIVATE: act_q         <= wdata[0];
                IDX_IO_HI:    set_q.io_hi   <= wdata;
                IDX_IO_LO:    set_q.io_lo   <= wdata;
                IDX_IRQ_LVL:  set_q.irq_lvl <= wdata[IRQ_LVL_W-1:0];
                IDX_IRQ_TYP:  set_q.irq_typ <= wdata[IRQ_TYP_W-1:0];
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/cfg_shift_chain.sv
module cfg_shift_chain #(
    parameter int W = 22
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         start,
    input  logic [W-1:0] load_val,
    output logic         sdata,
    output logic         busy_q,
    output logic         done_q
);
    localparam int CNT_W = $clog2(W + 1);
    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

    logic [W-1:0]     sh_q;
    logic [CNT_W-1:0] cnt_q;

    assign sdata = sh_q[W-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            sh_q   <= '0;
            cnt_q  <= '0;
            busy_q <= 1'b0;
            done_q <= 1'b0;
        end else if (start) begin
            sh_q   <= load_val;
            cnt_q  <= CNT_W'(W);
            busy_q <= 1'b1;
            done_q <= 1'b0;
        end else if (busy_q) begin
            sh_q <= {sh_q[W-2:0], 1'b0};
            if (cnt_q == CNT_ONE) begin
                busy_q <= 1'b0;
                done_q <= 1'b1;
                cnt_q  <= '0;
            end else begin
                cnt_q <= cnt_q - CNT_ONE;
            end
        end
    end

endmodule

// File: rtl/cfg_space_top.sv
module cfg_space_top
    import cfg_space_pkg::*;
#(
    parameter int FETCH_LAT = 4,
    parameter int RES_LEN   = 16
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [7:0] reg_idx,
    input  logic       rd_stb,
    input  logic       wr_stb,
    input  logic [7:0] wr_data,
    input  logic [1:0] ctl_state,
    output logic [7:0] rd_data,
    output logic       chain_sdata,
    output logic       chain_en,
    output logic       dev_active
);
    logic             in_cfg;
    logic             res_take;
    logic [DAT_W-1:0] res_q;
    logic             res_valid;
    settings_t        set_q;
    logic             act_q;
    logic             start;
    logic             busy;
    logic             done;
    logic [DAT_W-1:0] rd_next;
    logic [DAT_W-1:0] rd_q;

    assign in_cfg   = (ctl_state_e'(ctl_state) == ST_CONFIG);
    assign res_take = rd_stb && in_cfg && (reg_idx == IDX_RES_DATA);

    cfg_res_port #(
        .FETCH_LAT (FETCH_LAT),
        .RES_LEN   (RES_LEN)
    ) u_res (
        .clk     (clk),
        .rst     (rst),
        .take    (res_take),
        .byte_q  (res_q),
        .valid_q (res_valid)
    );

    cfg_regs u_regs (
        .clk   (clk),
        .rst   (rst),
        .wr_en (wr_stb && in_cfg),
        .idx   (reg_idx),
        .wdata (wr_data),
        .busy  (busy),
        .set_q (set_q),
        .act_q (act_q),
        .start (start)
    );

    cfg_shift_chain #(
        .W (CHAIN_W)
    ) u_chain (
        .clk      (clk),
        .rst      (rst),
        .start    (start),
        .load_val (set_q),
        .sdata    (chain_sdata),
        .busy_q   (busy),
        .done_q   (done)
    );

    always_comb begin
        rd_next = '0;
        if (in_cfg) begin
            case (reg_idx)
                IDX_RES_DATA: rd_next = res_q;
                IDX_RES_STAT: rd_next = DAT_W'(res_valid);
                IDX_ACTIVATE: rd_next = DAT_W'(act_q);
                IDX_IO_HI:    rd_next = set_q.io_hi;
                IDX_IO_LO:    rd_next = set_q.io_lo;
                IDX_IRQ_LVL:  rd_next = DAT_W'(set_q.irq_lvl);
                IDX_IRQ_TYP:  rd_next = DAT_W'(set_q.irq_typ);
                default:      rd_next = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst)         rd_q <= '0;
        else if (rd_stb) rd_q <= rd_next;
    end

    assign rd_data    = rd_q;
    assign chain_en   = busy;
    assign dev_active = act_q && done && !busy;

endmodule

// File: rtl/cfg_space_chk.sv
module cfg_space_chk (
    input logic       clk,
    input logic       rst,
    input logic [7:0] reg_idx,
    input logic       rd_stb,
    input logic       wr_stb,
    input logic [7:0] wr_data,
    input logic [1:0] ctl_state,
    input logic [7:0] rd_data,
    input logic       chain_en,
    input logic       dev_active,
    input logic       res_valid
);
    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        rst |=> (!dev_active && !chain_en && rd_data == 8'h00));

    // R9
    active_after_chain_chk: assert property (@(posedge clk) disable iff (rst)
        dev_active |-> !chain_en);

    // R2
    gated_read_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_stb && ctl_state != 2'd3) |=> rd_data == 8'h00);

    // R3
    irq_type_bits_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_stb && reg_idx == 8'h71) |=> rd_data[7:2] == 6'd0);

    // R5
    status_clears_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_stb && reg_idx == 8'h04 && ctl_state == 2'd3 && res_valid) |=> !res_valid);

    // R8
    chain_start_cause_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(chain_en) |-> $past(wr_stb && reg_idx == 8'h30 && wr_data[0] && ctl_state == 2'd3));

    // R11
    rd_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !rd_stb |=> $stable(rd_data));

endmodule

bind cfg_space_top cfg_space_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .reg_idx    (reg_idx),
    .rd_stb     (rd_stb),
    .wr_stb     (wr_stb),
    .wr_data    (wr_data),
    .ctl_state  (ctl_state),
    .rd_data    (rd_data),
    .chain_en   (chain_en),
    .dev_active (dev_active),
    .res_valid  (res_valid)
);

// File: tb/sim_cfg_space_top.sv
`timescale 1ns/1ps
module sim_cfg_space_top;
    localparam int LAT   = 4;
    localparam int RLEN  = 16;
    localparam int CW    = 22;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] reg_idx = '0;
    logic       rd_stb = 1'b0;
    logic       wr_stb = 1'b0;
    logic [7:0] wr_data = '0;
    logic [1:0] ctl_state = 2'd3;
    logic [7:0] rd_data;
    logic       chain_sdata;
    logic       chain_en;
    logic       dev_active;

    int n_checks = 0;
    int n_fail   = 0;
    int next_byte = 0;

    always #5 clk = ~clk;

    cfg_space_top u0 (
        .clk(clk), .rst(rst), .reg_idx(reg_idx), .rd_stb(rd_stb),
        .wr_stb(wr_stb), .wr_data(wr_data), .ctl_state(ctl_state),
        .rd_data(rd_data), .chain_sdata(chain_sdata), .chain_en(chain_en),
        .dev_active(dev_active)
    );

    function automatic logic [7:0] exp_byte(input int n);
        return 8'(((n % RLEN) * 37 + 90) % 256);
    endfunction

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic do_rd(input logic [7:0] idx, output logic [7:0] val);
        reg_idx = idx; rd_stb = 1'b1;
        @(negedge clk);
        rd_stb = 1'b0;
        val = rd_data;
    endtask

    task automatic do_wr(input logic [7:0] idx, input logic [7:0] d);
        reg_idx = idx; wr_data = d; wr_stb = 1'b1;
        @(negedge clk);
        wr_stb = 1'b0;
    endtask

    task automatic poll_byte(output logic [7:0] val);
        logic [7:0] s;
        s = 8'h00;
        for (int i = 0; i < 20 && s[0] !== 1'b1; i++) do_rd(8'h05, s);
        do_rd(8'h04, val);
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        check("R1 dev_active", dev_active, 0);
        check("R1 chain_en", chain_en, 0);
        check("R1 rd_data", rd_data, 0);
        rst = 1'b0;
    endtask

    task automatic t_status_after_reset();
        logic [7:0] v;
        for (int i = 0; i < LAT; i++) begin
            do_rd(8'h05, v);
            check("R4 status low during fetch", v, 0);
        end
        do_rd(8'h05, v);
        check("R4 status set after FETCH_LAT", v, 1);
        do_rd(8'h04, v);
        check("R1 first byte is byte 0", v, exp_byte(0));
        next_byte = 1;
        for (int i = 0; i < LAT; i++) begin
            do_rd(8'h05, v);
            check("R5 status cleared after read", v, 0);
        end
        do_rd(8'h05, v);
        check("R5 status back after FETCH_LAT", v, 1);
    endtask

    task automatic t_sequence();
        logic [7:0] v;
        for (int i = 0; i < RLEN + 4; i++) begin
            poll_byte(v);
            check("R6 resource byte", v, exp_byte(next_byte));
            next_byte++;
        end
    endtask

    task automatic t_no_advance();
        logic [7:0] v;
        poll_byte(v);
        check("R6 byte before stall", v, exp_byte(next_byte));
        next_byte++;
        do_rd(8'h04, v);
        check("R7 stale read returns previous byte", v, exp_byte(next_byte - 1));
        poll_byte(v);
        check("R7 pointer not advanced by stale read", v, exp_byte(next_byte));
        next_byte++;
        repeat (LAT + 2) @(negedge clk);
        ctl_state = 2'd1;
        do_rd(8'h04, v);
        check("R2 read outside config is zero", v, 0);
        ctl_state = 2'd3;
        do_rd(8'h04, v);
        check("R2 gated read did not advance", v, exp_byte(next_byte));
        next_byte++;
    endtask

    task automatic t_gating();
        logic [7:0] v;
        ctl_state = 2'd2;
        do_wr(8'h60, 8'hAB);
        do_wr(8'h30, 8'h01);
        check("R2 no transfer from gated activate", chain_en, 0);
        do_rd(8'h60, v);
        check("R2 gated read zero", v, 0);
        ctl_state = 2'd3;
        do_rd(8'h60, v);
        check("R2 gated write discarded", v, 0);
        do_rd(8'h30, v);
        check("R2 gated activate discarded", v, 0);
        check("R2 device still idle", dev_active, 0);
    endtask

    task automatic t_unused_bits();
        logic [7:0] v;
        do_wr(8'h70, 8'hFF);
        do_rd(8'h70, v);
        check("R3 irq level bits", v, 8'h0F);
        do_wr(8'h71, 8'hFF);
        do_rd(8'h71, v);
        check("R3 irq type bits", v, 8'h03);
        do_wr(8'h22, 8'hFF);
        do_rd(8'h22, v);
        check("R3 unassigned index", v, 0);
        do_rd(8'h05, v);
        check("R4 status upper bits zero", v & 8'hFE, 0);
        repeat (3) @(negedge clk);
        check("R11 rd_data held without strobe", rd_data, v);
    endtask

    task automatic t_activate();
        logic [CW-1:0] exp;
        logic [7:0] v;
        exp = {8'hA5, 8'h3C, 4'h9, 2'h2};
        do_wr(8'h60, 8'hA5);
        do_wr(8'h61, 8'h3C);
        do_wr(8'h70, 8'h09);
        do_wr(8'h71, 8'h02);
        do_wr(8'h30, 8'h01);
        for (int i = 0; i < CW; i++) begin
            check("R8 chain_en during transfer", chain_en, 1);
            check("R8 chain bit MSB first", chain_sdata, exp[CW-1-i]);
            check("R9 inactive while shifting", dev_active, 0);
            @(negedge clk);
        end
        check("R8 chain_en ends after 22 bits", chain_en, 0);
        check("R9 active after last bit", dev_active, 1);
        do_rd(8'h30, v);
        check("R8 activate readback", v, 1);
    endtask

    task automatic t_busy_ignore();
        logic [7:0] v;
        do_wr(8'h30, 8'h01);
        check("R9 restart holds device", dev_active, 0);
        do_wr(8'h60, 8'h11);
        do_wr(8'h30, 8'h00);
        for (int i = 0; i < 40 && chain_en; i++) @(negedge clk);
        check("R10 deactivate during busy discarded", dev_active, 1);
        do_rd(8'h60, v);
        check("R10 setting write during busy discarded", v, 8'hA5);
        do_wr(8'h30, 8'h00);
        check("R9 deactivate drops device", dev_active, 0);
        do_rd(8'h30, v);
        check("R9 activate bit cleared", v, 0);
    endtask

    initial begin
        #2ms;
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_status_after_reset();
        t_sequence();
        t_no_advance();
        t_gating();
        t_unused_bits();
        t_activate();
        t_busy_ignore();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule